// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the digital serial port of a multi-register sigma-delta converter. A host reaches it as an SPI slave over chip-select (active low), a serial clock that idles high, a data-in line and one shared output line. The output line carries read data while a read is shifting, and otherwise shows whether a fresh conversion result is waiting. Each access opens with an 8-bit command byte. That byte picks a register and the access direction, and it can put the port into a continuous-read state.

The port holds a read-only status byte, mode and configuration words, the conversion result word and an offset word. The modulator and the filter are not part of this block. Each finished conversion arrives as a one-cycle strobe with a parallel word. Sending forty 1 bits in a row returns every register to its reset value and leaves continuous read. Chip-select can be held low for 3-wire use.

The serial clock and data-in are sampled in the system clock domain. Each serial-clock phase must last at least two system clock cycles.

Top module: `adcSpiPort`

## Requirements
- R1: The command byte is sent MSB first. Bit 7 must be 0, or the byte is dropped and the next byte is again a command. Bit 6 = 1 means read and 0 means write. Bits 5:3 select the register: 0 status (8 bits, read-only), 1 mode (24), 2 configuration (24), 3 conversion data (24, read-only), 7 offset (24). Selects 4 to 6 are unused.
- R2: After reset the registers hold these values: status 0x80, mode 0x080060, configuration 0x000117, data 0x000000, offset 0x800000.
- R3: All fields are shifted MSB first. Data-in is taken on the rising serial-clock edge. The output line changes only after a falling edge while read data is being driven.
- R4: A write command to select 1, 2 or 7 loads the next 24 data-in bits into that register. A write to any other select is dropped.
- R5: A conversion strobe loads the data register and clears status bit 7. While chip-select is low and no read is shifting, the output line then reads 0.
- R6: Reading the data register sets status bit 7 again. After that read the output line stays high until the next conversion strobe.
- R7: Command 0x5C enters continuous read. From then on, each conversion drives the output line low and then shifts out its 24-bit result on the following serial clocks, with no new command. After the 24th bit the line returns high.
- R8: Forty consecutive 1 bits on data-in, while chip-select is low, restore all R2 values and leave continuous read. A run of 39 ones ended by a 0 changes no register.
- R9: While chip-select is high the output line is 1. Raising chip-select discards a partial transfer, and the next byte is taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| convValid | input | 1 | One-cycle strobe for a finished conversion |
| convData | input | 24 | Conversion result that goes with the strobe |
| doutRdy | output | 1 | Read data while a read is shifting, otherwise the not-ready flag |

## Verification
Register writes use asymmetric values such as 0x123456 and 0xA5C3F0. Reading them back tells correct MSB-first ordering and select decoding apart from bit reversal or swapped registers. Conversion words are read both by explicit command and through continuous read, so the two paths that load the result shifter are each exercised. Runs of exactly 39 and exactly 40 ones bracket the reset detector's count. A write cut short by chip-select, and a command with bit 7 set, check that partial or invalid traffic leaves register contents alone.

// File: rtl/adcSpiPkg.sv
package adcSpiPkg;
  typedef enum logic [2:0] {PH_CMD, PH_RD, PH_WR, PH_CWAIT, PH_CSEND} phase_t;

  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_MODE   = 3'd1;
  localparam logic [2:0] SEL_CONFIG = 3'd2;
  localparam logic [2:0] SEL_DATA   = 3'd3;
  localparam logic [2:0] SEL_OFFSET = 3'd7;

  // strobes from control to datapath, valid for one clk
  typedef struct packed {
    logic       softRst;
    logic       loadRead;
    logic       shiftOut;
    logic       shiftIn;
    logic       commit;
    logic       driveShift;
    logic [2:0] sel;
  } strobe_t;
endpackage

// File: rtl/adcSpiCtrl.sv
module adcSpiCtrl
  import adcSpiPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int STAT_W   = 8,
  parameter int RST_ONES = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    din,
  input  logic    notReady,
  output strobe_t st
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ONES_W = $clog2(RST_ONES + 1);

  phase_t            phase;
  logic              sclkQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic [6:0]        cmdSh;
  logic [2:0]        curSel;

  logic             rise, fall, cmdDone, lastBit, softHit;
  logic [2:0]       byteSel;
  logic             readable, writable, creadCmd;
  logic [CNT_W-1:0] curLen;

  assign rise     = !csN && sclk && !sclkQ;
  assign fall     = !csN && !sclk && sclkQ;
  // completed byte is {cmdSh, din}: bit7=cmdSh[6], bit6=cmdSh[5], sel=cmdSh[4:2], bit2=cmdSh[1]
  assign byteSel  = cmdSh[4:2];
  assign readable = (byteSel == SEL_STATUS) || (byteSel == SEL_MODE) || (byteSel == SEL_CONFIG) ||
                    (byteSel == SEL_DATA) || (byteSel == SEL_OFFSET);
  assign writable = (byteSel == SEL_MODE) || (byteSel == SEL_CONFIG) || (byteSel == SEL_OFFSET);
  assign creadCmd = cmdSh[1] && (byteSel == SEL_DATA);
  assign curLen   = (curSel == SEL_STATUS) ? CNT_W'(STAT_W - 1) : CNT_W'(DATA_W - 1);
  assign lastBit  = (bitCnt == curLen);
  assign cmdDone  = rise && (phase == PH_CMD) && (bitCnt == CNT_W'(7));
  assign softHit  = rise && din && (onesCnt == ONES_W'(RST_ONES - 1));

  always_comb begin
    st            = '0;
    st.sel        = curSel;
    st.driveShift = (phase == PH_RD) || (phase == PH_CSEND);
    st.shiftOut   = fall && st.driveShift;
    if (softHit) begin
      st.softRst = 1'b1;
    end else if (cmdDone && !cmdSh[6] && cmdSh[5] && readable && !creadCmd) begin
      st.loadRead = 1'b1;
      st.sel      = byteSel;
    end else if (rise && (phase == PH_WR)) begin
      st.shiftIn = 1'b1;
      st.commit  = lastBit;
    end else if ((phase == PH_CWAIT) && !csN && !notReady) begin
      st.loadRead = 1'b1;
      st.sel      = SEL_DATA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      sclkQ   <= 1'b1;
      bitCnt  <= '0;
      onesCnt <= '0;
      cmdSh   <= '0;
      curSel  <= SEL_STATUS;
    end else begin
      sclkQ <= sclk;
      if (st.softRst) begin
        phase   <= PH_CMD;
        bitCnt  <= '0;
        onesCnt <= '0;
        cmdSh   <= '0;
        curSel  <= SEL_STATUS;
      end else if (csN) begin
        bitCnt  <= '0;
        onesCnt <= '0;
        if (phase == PH_CSEND)      phase <= PH_CWAIT;
        else if (phase != PH_CWAIT) phase <= PH_CMD;
      end else begin
        if (rise) onesCnt <= din ? onesCnt + 1'b1 : '0;
        case (phase)
          PH_CMD: if (rise) begin
            cmdSh <= {cmdSh[5:0], din};
            if (cmdDone) begin
              bitCnt <= '0;
              if (!cmdSh[6]) begin
                if (cmdSh[5] && readable) begin
                  curSel <= byteSel;
                  phase  <= creadCmd ? PH_CWAIT : PH_RD;
                end else if (!cmdSh[5] && writable) begin
                  curSel <= byteSel;
                  phase  <= PH_WR;
                end
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_RD, PH_WR, PH_CSEND: if (rise) begin
            if (lastBit) begin
              bitCnt <= '0;
              phase  <= (phase == PH_CSEND) ? PH_CWAIT : PH_CMD;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_CWAIT: if (!notReady) begin
            phase  <= PH_CSEND;
            bitCnt <= '0;
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/adcSpiDpath.sv
module adcSpiDpath
  import adcSpiPkg::*;
#(
  parameter int               DATA_W   = 24,
  parameter int               STAT_W   = 8,
  parameter logic [DATA_W-1:0] MODE_RST = 24'h080060,
  parameter logic [DATA_W-1:0] CONF_RST = 24'h000117,
  parameter logic [DATA_W-1:0] OFFS_RST = 24'h800000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              din,
  input  logic              convValid,
  input  logic [DATA_W-1:0] convData,
  input  strobe_t           st,
  output logic              notReady,
  output logic              doutRdy
);
  logic [DATA_W-1:0] modeReg, confReg, dataReg, offsReg, sh;
  logic [DATA_W-2:0] inSh;
  logic              outBit;
  logic [STAT_W-1:0] statusByte;

  assign statusByte = {notReady, {(STAT_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_RST;
      confReg  <= CONF_RST;
      offsReg  <= OFFS_RST;
      dataReg  <= '0;
      notReady <= 1'b1;
      sh       <= '0;
      inSh     <= '0;
      outBit   <= 1'b1;
    end else if (st.softRst) begin
      modeReg  <= MODE_RST;
      confReg  <= CONF_RST;
      offsReg  <= OFFS_RST;
      dataReg  <= '0;
      notReady <= 1'b1;
      sh       <= '0;
      inSh     <= '0;
      outBit   <= 1'b1;
    end else begin
      if (st.loadRead) begin
        case (st.sel)
          SEL_STATUS: sh <= {statusByte, {(DATA_W-STAT_W){1'b0}}};
          SEL_MODE:   sh <= modeReg;
          SEL_CONFIG: sh <= confReg;
          SEL_DATA:   sh <= dataReg;
          default:    sh <= offsReg;
        endcase
        outBit <= 1'b0;
      end else if (st.shiftOut) begin
        outBit <= sh[DATA_W-1];
        sh     <= {sh[DATA_W-2:0], 1'b0};
      end
      if (st.shiftIn) inSh <= {inSh[DATA_W-3:0], din};
      if (st.commit) begin
        case (st.sel)
          SEL_MODE:   modeReg <= {inSh, din};
          SEL_CONFIG: confReg <= {inSh, din};
          SEL_OFFSET: offsReg <= {inSh, din};
          default:    ;
        endcase
      end
      if (convValid) begin
        dataReg  <= convData;
        notReady <= 1'b0;
      end else if (st.loadRead && (st.sel == SEL_DATA)) begin
        notReady <= 1'b1;
      end
    end
  end

  assign doutRdy = csN ? 1'b1 : (st.driveShift ? outBit : notReady);
endmodule

// File: rtl/adcSpiPort.sv
module adcSpiPort
  import adcSpiPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int STAT_W   = 8,
  parameter int RST_ONES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              convValid,
  input  logic [DATA_W-1:0] convData,
  output logic              doutRdy
);
  strobe_t st;
  logic    notReady;

  adcSpiCtrl #(.DATA_W(DATA_W), .STAT_W(STAT_W), .RST_ONES(RST_ONES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .notReady(notReady), .st(st)
  );

  adcSpiDpath #(.DATA_W(DATA_W), .STAT_W(STAT_W)) uDpath (
    .clk(clk), .rstN(rstN), .csN(csN), .din(din), .convValid(convValid),
    .convData(convData), .st(st), .notReady(notReady), .doutRdy(doutRdy)
  );
endmodule

// File: rtl/adcSpiChk.sv
module adcSpiChk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       convValid,
  input logic       doutRdy,
  input logic       notReady,
  input logic       loadRead,
  input logic       commit,
  input logic       softRst,
  input logic       driveShift,
  input logic [2:0] sel
);
  AST_CONV_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (convValid && !softRst) |=> !notReady);  // R5

  AST_DATA_READ_SETS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (loadRead && sel == 3'd3 && !convValid) |=> notReady);  // R6

  AST_SOFT_RESET_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !convValid) |=> notReady);  // R8

  AST_DOUT_HOLDS_HIGH_SCLK: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk) && !csN && !$past(csN) && driveShift && $past(driveShift))
      |-> $stable(doutRdy));  // R3

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadRead, commit, softRst}));  // R1
endmodule

bind adcSpiPort adcSpiChk uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .convValid(convValid),
  .doutRdy(doutRdy), .notReady(notReady), .loadRead(st.loadRead),
  .commit(st.commit), .softRst(st.softRst), .driveShift(st.driveShift), .sel(st.sel)
);

// File: tb/tb_adcSpiPort.sv
module tb_adcSpiPort;
  logic        clk = 1'b0;
  logic        rstN, csN, sclk, din, convValid;
  logic [23:0] convData;
  logic        doutRdy;
  int          tests = 0;
  int          fails = 0;

  adcSpiPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .convValid(convValid), .convData(convData), .doutRdy(doutRdy)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitX(input logic b, output logic o);
    @(negedge clk); sclk = 1'b0; din = b;
    repeat (3) @(negedge clk);
    o = doutRdy; sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [31:0] w, output logic [31:0] r);
    logic o;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitX(w[i], o);
      r[i] = o;
    end
  endtask

  task automatic readReg(input logic [2:0] sel, input int n, output logic [31:0] v);
    logic [31:0] d;
    xfer(8, {24'h0, 2'b01, sel, 3'b000}, d);
    xfer(n, 32'h0, v);
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [23:0] val);
    logic [31:0] d;
    xfer(8, {24'h0, 2'b00, sel, 3'b000}, d);
    xfer(24, {8'h0, val}, d);
  endtask

  task automatic conv(input logic [23:0] val);
    @(negedge clk); convData = val; convValid = 1'b1;
    @(negedge clk); convValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkResetValues(input string req);
    logic [31:0] v;
    readReg(3'd0, 8, v);  check(req, v, 32'h80);
    readReg(3'd1, 24, v); check(req, v, 32'h080060);
    readReg(3'd2, 24, v); check(req, v, 32'h000117);
    readReg(3'd3, 24, v); check(req, v, 32'h000000);
    readReg(3'd7, 24, v); check(req, v, 32'h800000);
  endtask

  task automatic tReset;
    check("R9 idle high with cs high", {31'h0, doutRdy}, 32'h1);
    @(negedge clk); csN = 1'b0;
    checkResetValues("R2 reset value");
  endtask

  task automatic tWriteRead;
    logic [31:0] v;
    writeReg(3'd1, 24'h123456);
    writeReg(3'd2, 24'hA5C3F0);
    writeReg(3'd7, 24'h0F00FF);
    readReg(3'd1, 24, v); check("R4 mode write R3 order", v, 32'h123456);
    readReg(3'd2, 24, v); check("R4 config write", v, 32'hA5C3F0);
    readReg(3'd7, 24, v); check("R4 offset write", v, 32'h0F00FF);
  endtask

  task automatic tDropped;
    logic [31:0] v;
    xfer(8, 32'h88, v);          // bit 7 set: dropped
    xfer(24, 32'h00FFFFFF, v);   // taken as dropped commands
    readReg(3'd1, 24, v); check("R1 bit7 command dropped", v, 32'h123456);
    writeReg(3'd3, 24'h777777);  // write to read-only data, dropped with its tail
    readReg(3'd3, 24, v); check("R4 data not writable", v, 32'h000000);
  endtask

  task automatic tConversion;
    logic [31:0] v;
    conv(24'hABCDEF);
    check("R5 pin low after conversion", {31'h0, doutRdy}, 32'h0);
    readReg(3'd0, 8, v);  check("R5 status ready clear", v, 32'h00);
    readReg(3'd3, 24, v); check("R5 data value", v, 32'hABCDEF);
    repeat (2) @(negedge clk);
    check("R6 pin high after data read", {31'h0, doutRdy}, 32'h1);
    readReg(3'd0, 8, v);  check("R6 status ready set", v, 32'h80);
  endtask

  task automatic tAbort;
    logic [31:0] v;
    xfer(8, 32'h08, v);          // write mode
    xfer(12, 32'hFFF, v);
    @(negedge clk); csN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 pin high with cs high", {31'h0, doutRdy}, 32'h1);
    csN = 1'b0;
    readReg(3'd1, 24, v); check("R9 aborted write discarded", v, 32'h123456);
  endtask

  task automatic tNearReset;
    logic [31:0] v;
    xfer(32, 32'hFFFFFFFF, v);
    xfer(8, 32'hFE, v);          // 39 ones then a 0
    readReg(3'd1, 24, v); check("R8 39 ones no reset", v, 32'h123456);
  endtask

  task automatic tCread;
    logic [31:0] v;
    xfer(8, 32'h5C, v);
    repeat (2) @(negedge clk);
    check("R7 waiting pin high", {31'h0, doutRdy}, 32'h1);
    conv(24'h13579B);
    check("R7 pin low on conversion", {31'h0, doutRdy}, 32'h0);
    xfer(24, 32'h0, v); check("R7 first result", v, 32'h13579B);
    repeat (2) @(negedge clk);
    check("R7 pin high after result", {31'h0, doutRdy}, 32'h1);
    conv(24'h2468AC);
    xfer(24, 32'h0, v); check("R7 second result no command", v, 32'h2468AC);
    xfer(32, 32'hFFFFFFFF, v);
    xfer(8, 32'hFF, v);          // 40 ones
    repeat (2) @(negedge clk);
    check("R8 pin high after reset", {31'h0, doutRdy}, 32'h1);
    checkResetValues("R8 reset restores");
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b1; din = 1'b0; convValid = 1'b0; convData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tWriteRead();
    tDropped();
    tConversion();
    tAbort();
    tNearReset();
    tCread();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule